// File: doc/BRIEF.md
# Dual Pausable Countdown Timer

This peripheral holds two independent down-counters behind a small register bus. Each counter has a count value and a period value. A software write to a counter's count address loads both at once. Each counter takes its decrement strobe from one of two tick inputs: a strobe at half the master clock rate, or a strobe from an external oscillator. A shared control word holds, for each counter, its run enable, its tick-source select and its interrupt enable.

When a running counter expires, it reloads from its period value and raises a one-cycle interrupt pulse, provided its interrupt enable is set. Clearing a counter's run enable freezes the count in place. Setting the enable again resumes counting from the frozen value, with no reload. Software can therefore start and stop a counter as often as it likes without losing the count. Both count values and the control word can be read back.

Top module: `twin_timer`

## Requirements
- R1: After the active-low asynchronous reset, the control word reads 0, both counts read 0 and both interrupt outputs are low.
- R2: The control word is at address 0x38. Bit 10 and bit 11 are the run enables of timer 0 and timer 1. Bit 8 and bit 9 are their tick-source selects. Bit 1 and bit 2 are their interrupt enables. All other bits read back as 0 whatever is written.
- R3: A write to address 0x3A (timer 0) or 0x3B (timer 1) sets that timer's count and its period to the written value. Reading the same address returns the count.
- R4: A running timer decrements by one on each tick of its selected source. Select 0 picks `half_tick_i` and select 1 picks `osc_tick_i`. A change of select takes effect from the next tick.
- R5: On a tick that finds the count at 1 or 0, the timer loads its period instead of decrementing. In the following cycle its `irq_o` bit is high for exactly one cycle, and only if its interrupt enable was set. At no other time is `irq_o` high.
- R6: While a timer's run enable is 0, its count holds. Setting the enable again resumes counting from the held value.
- R7: When a count write and a tick arrive in the same cycle, the written value wins and no decrement or reload happens.
- R8: Reads change no state. A read of any unmapped address returns 0, and `rdata_o` is 0 whenever no read is in progress.
- R9: The two timers are independent. Activity on one never changes the count, period or interrupt of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational |
| half_tick_i | input | 1 | Single-cycle strobe at half the master clock rate |
| osc_tick_i | input | 1 | Single-cycle strobe from the external oscillator |
| irq_o | output | 2 | One-cycle expiry pulse per timer |

## Verification
`half_tick_i` alternates every cycle. `osc_tick_i` follows an irregular pseudo-random pattern, and in one phase fires every cycle. A timer wired to the wrong source or decrementing on the wrong strobe therefore drifts away from the reference model within a few ticks. Directed sequences cover the following cases. Pause and resume show whether the count is held or reloaded. Writes land on tick cycles to expose the load/decrement priority. Period 0 and period 1 give an interrupt on every tick. Running timer 1 with its interrupt disabled separates a gated interrupt from an ungated one. Interrupts are compared every cycle, and register reads are compared against the model after every phase.

// File: rtl/twin_timer_pkg.sv
`timescale 1ns/1ps
package twin_timer_pkg;
  localparam int unsigned NUM_TMR = 2;
  // control word bit positions, timer i at LSB+i
  localparam int unsigned EN_LSB  = 10;
  localparam int unsigned SRC_LSB = 8;
  localparam int unsigned IE_LSB  = 1;

  typedef struct packed {
    logic en;
    logic src;
    logic ie;
  } tmr_cfg_t;
endpackage

// File: rtl/twin_timer_regif.sv
`timescale 1ns/1ps
module twin_timer_regif
  import twin_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h38,
  parameter logic [ADDR_W-1:0] CNT_BASE  = 'h3A
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            sel_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  cnt_i,
  output tmr_cfg_t [NUM_TMR-1:0]          cfg_o,
  output logic [NUM_TMR-1:0]              cnt_wr_o
);
  logic [NUM_TMR-1:0] en_q, src_q, ie_q;
  logic [DATA_W-1:0]  ctrl_word;
  logic               wr_ctrl;

  assign wr_ctrl = sel_i && we_i && (addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      src_q <= '0;
      ie_q  <= '0;
    end else if (wr_ctrl) begin
      en_q  <= wdata_i[EN_LSB  +: NUM_TMR];
      src_q <= wdata_i[SRC_LSB +: NUM_TMR];
      ie_q  <= wdata_i[IE_LSB  +: NUM_TMR];
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_LSB  +: NUM_TMR] = en_q;
    ctrl_word[SRC_LSB +: NUM_TMR] = src_q;
    ctrl_word[IE_LSB  +: NUM_TMR] = ie_q;
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] CntAddr = CNT_BASE + ADDR_W'(i);
    assign cnt_wr_o[i]  = sel_i && we_i && (addr_i == CntAddr);
    assign cfg_o[i].en  = en_q[i];
    assign cfg_o[i].src = src_q[i];
    assign cfg_o[i].ie  = ie_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && !we_i) begin
      if (addr_i == CTRL_ADDR) rdata_o = ctrl_word;
      for (int i = 0; i < NUM_TMR; i++) begin
        if (addr_i == CNT_BASE + ADDR_W'(i)) rdata_o = cnt_i[i];
      end
    end
  end
endmodule

// File: rtl/twin_timer_tick_sel.sv
`timescale 1ns/1ps
module twin_timer_tick_sel
  import twin_timer_pkg::*;
(
  input  logic                   half_tick_i,
  input  logic                   osc_tick_i,
  input  tmr_cfg_t [NUM_TMR-1:0] cfg_i,
  output logic [NUM_TMR-1:0]     step_o
);
  for (genvar i = 0; i < NUM_TMR; i++) begin : g_sel
    logic src_tick;
    assign src_tick  = cfg_i[i].src ? osc_tick_i : half_tick_i;
    assign step_o[i] = cfg_i[i].en && src_tick;
  end
endmodule

// File: rtl/twin_timer_core.sv
`timescale 1ns/1ps
module twin_timer_core #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] per_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] cnt_q, per_q;
  logic              irq_q;
  logic              expire;

  // count 1 or 0 on a tick: reload instead of wrapping
  assign expire = step_i && !ld_i && (cnt_q < DATA_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= expire && ie_i;
      if (ld_i) begin
        cnt_q <= ld_val_i;
        per_q <= ld_val_i;
      end else if (expire) begin
        cnt_q <= per_q;
      end else if (step_i) begin
        cnt_q <= cnt_q - DATA_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/twin_timer.sv
`timescale 1ns/1ps
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h38,
  parameter logic [ADDR_W-1:0] CNT_BASE  = 'h3A
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               half_tick_i,
  input  logic               osc_tick_i,
  output logic [NUM_TMR-1:0] irq_o
);
  tmr_cfg_t [NUM_TMR-1:0]         cfg;
  logic [NUM_TMR-1:0]             cnt_wr, step, cfg_en, cfg_ie;
  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_val, per_val;

  twin_timer_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CNT_BASE(CNT_BASE)
  ) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .cnt_i(cnt_val), .cfg_o(cfg), .cnt_wr_o(cnt_wr)
  );

  twin_timer_tick_sel u_tick_sel (
    .half_tick_i(half_tick_i), .osc_tick_i(osc_tick_i),
    .cfg_i(cfg), .step_o(step)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_core
    assign cfg_en[i] = cfg[i].en;
    assign cfg_ie[i] = cfg[i].ie;
    twin_timer_core #(.DATA_W(DATA_W)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step[i]),
      .ld_i(cnt_wr[i]), .ld_val_i(wdata_i), .ie_i(cfg[i].ie),
      .cnt_o(cnt_val[i]), .per_o(per_val[i]), .irq_o(irq_o[i])
    );
  end
endmodule

// File: rtl/twin_timer_chk.sv
`timescale 1ns/1ps
module twin_timer_chk
  import twin_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h38
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            sel_i,
  input logic                            we_i,
  input logic [ADDR_W-1:0]               addr_i,
  input logic [DATA_W-1:0]               wdata_i,
  input logic [NUM_TMR-1:0]              wr_i,
  input logic [NUM_TMR-1:0]              step_i,
  input logic [NUM_TMR-1:0]              en_i,
  input logic [NUM_TMR-1:0]              ie_i,
  input logic [NUM_TMR-1:0][DATA_W-1:0]  cnt_i,
  input logic [NUM_TMR-1:0][DATA_W-1:0]  per_i,
  input logic [NUM_TMR-1:0]              irq_i
);
  logic wr_ctrl;
  assign wr_ctrl = sel_i && we_i && (addr_i == CTRL_ADDR);

  assert_ctrl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (en_i == $past(wdata_i[EN_LSB +: NUM_TMR])) &&
                (ie_i == $past(wdata_i[IE_LSB +: NUM_TMR])));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    assert_load_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i[i] |=> (cnt_i[i] == $past(wdata_i)) && (per_i[i] == $past(wdata_i)) && !irq_i[i]);

    assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i[i] && !wr_i[i] && cnt_i[i] > DATA_W'(1)) |=>
        (cnt_i[i] == $past(cnt_i[i]) - DATA_W'(1)));

    assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i[i] && !wr_i[i] && cnt_i[i] <= DATA_W'(1)) |=>
        (cnt_i[i] == $past(per_i[i])) && (irq_i[i] == $past(ie_i[i])));

    assert_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[i] |-> $past(step_i[i] && ie_i[i] && !wr_i[i]));

    assert_hold_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[i] && !wr_i[i]) |=> $stable(cnt_i[i]));

    assert_read_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && !we_i && !step_i[i]) |=> $stable(cnt_i[i]) && $stable(per_i[i]));
  end
endmodule

bind twin_timer twin_timer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(cnt_wr), .step_i(step),
  .en_i(cfg_en), .ie_i(cfg_ie), .cnt_i(cnt_val), .per_i(per_val), .irq_i(irq_o)
);

// File: tb/twin_timer_tb.sv
`timescale 1ns/1ps
module twin_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        half_tk = 1'b0, osc_tk = 1'b0;
  logic [1:0]  irq;
  logic [7:0]  lfsr = 8'hA5;
  bit          force_osc = 1'b0;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_cnt[2];
  int m_per[2];
  int m_ctrl;
  bit m_irq[2];

  always #2.5 clk = ~clk;

  twin_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .half_tick_i(half_tk),
    .osc_tick_i(osc_tk), .irq_o(irq)
  );

  always @(negedge clk) begin
    half_tk = ~half_tk;
    lfsr    = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    osc_tk  = force_osc | (lfsr[0] & ~lfsr[2]);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_per[i] = 0; m_irq[i] = 0;
      end
    end else begin
      int old_ctrl;
      old_ctrl = m_ctrl;
      for (int i = 0; i < 2; i++) begin
        bit en, src, ie, tick, wr;
        en   = old_ctrl[10+i];
        src  = old_ctrl[8+i];
        ie   = old_ctrl[1+i];
        tick = en && (src ? osc_tk : half_tk);
        wr   = sel && we && (addr == 8'h3A + i);
        m_irq[i] = 0;
        if (wr) begin
          m_cnt[i] = wdata; m_per[i] = wdata;
        end else if (tick) begin
          if (m_cnt[i] <= 1) begin
            m_cnt[i] = m_per[i]; m_irq[i] = ie;
          end else m_cnt[i] = m_cnt[i] - 1;
        end
      end
      if (sel && we && addr == 8'h38) m_ctrl = wdata & 16'h0F06;
    end
  end

  function automatic int m_read(input logic [7:0] a);
    if (a == 8'h38) return m_ctrl;
    if (a == 8'h3A) return m_cnt[0];
    if (a == 8'h3B) return m_cnt[1];
    return 0;
  endfunction

  // R5 / R9: interrupt compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 2; i++) begin
        checks++;
        if (irq[i] !== m_irq[i]) begin
          errors++;
          $display("FAIL R5 irq[%0d] t=%0t actual=%b expected=%b", i, $time, irq[i], m_irq[i]);
        end
      end
      checks++;
      if (!sel && rdata !== 16'h0) begin
        errors++;
        $display("FAIL R8 idle rdata actual=%h expected=0000", rdata);
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag, output logic [15:0] got);
    int exp;
    sel = 1; we = 0; addr = a;
    #1;
    exp = m_read(a);
    got = rdata;
    checks++;
    if (rdata !== 16'(exp)) begin
      errors++;
      $display("FAIL %s read %h actual=%h expected=%h", tag, a, rdata, 16'(exp));
    end
    @(negedge clk);
    sel = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] got;
    rd_chk(a, tag, got);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s direct %h actual=%h expected=%h", tag, a, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v1, v2;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd_exp(8'h38, 16'h0000, "R1");
    rd_exp(8'h3A, 16'h0000, "R1");
    rd_exp(8'h3B, 16'h0000, "R1");
    // R2 control mask and layout
    wr_reg(8'h38, 16'hFFFF);
    rd_exp(8'h38, 16'h0F06, "R2");
    wr_reg(8'h38, 16'h0000);
    rd_exp(8'h38, 16'h0000, "R2");
    // R3 load count and period
    wr_reg(8'h3A, 16'd5);
    rd_exp(8'h3A, 16'd5, "R3");
    wr_reg(8'h3B, 16'd3);
    rd_exp(8'h3B, 16'd3, "R3");
    // R4 timer 0 on half tick, irq on
    wr_reg(8'h38, 16'h0402);
    idle(40);
    rd_chk(8'h3A, "R4", v1);
    rd_exp(8'h3B, 16'd3, "R9");
    // R4/R5 timer 1 on osc, irq off
    wr_reg(8'h38, 16'h0E02);
    idle(60);
    rd_chk(8'h3B, "R5", v1);
    rd_chk(8'h3A, "R9", v1);
    // R6 pause timer 0, keep timer 1 running
    wr_reg(8'h3A, 16'd200);
    idle(7);
    wr_reg(8'h38, 16'h0A02);
    rd_chk(8'h3A, "R6", v1);
    idle(12);
    rd_chk(8'h3A, "R6", v2);
    checks++;
    if (v1 !== v2) begin
      errors++;
      $display("FAIL R6 held count actual=%h expected=%h", v2, v1);
    end
    wr_reg(8'h38, 16'h0E02);
    idle(9);
    rd_chk(8'h3A, "R6", v2);
    checks++;
    if (!(v2 < v1 && v2 > v1 - 16'd10)) begin
      errors++;
      $display("FAIL R6 resumed count actual=%h expected below %h", v2, v1);
    end
    // R4 switch timer 0 to osc while running
    wr_reg(8'h38, 16'h0F02);
    idle(30);
    rd_chk(8'h3A, "R4", v1);
    // R7 write on tick cycles (osc every cycle)
    force_osc = 1;
    for (int k = 0; k < 4; k++) begin
      wr_reg(8'h3A, 16'd9 + 16'(k));
      rd_exp(8'h3A, 16'd9 + 16'(k), "R7");
    end
    // R5 period 1 and period 0: irq every tick
    wr_reg(8'h3A, 16'd1);
    idle(6);
    wr_reg(8'h3A, 16'd0);
    idle(6);
    rd_exp(8'h3A, 16'd0, "R5");
    wr_reg(8'h3B, 16'd2);
    wr_reg(8'h38, 16'h0F06);
    idle(10);
    force_osc = 0;
    idle(40);
    // R8 reads without side effects, unmapped read
    rd_exp(8'h40, 16'h0000, "R8");
    rd_exp(8'h39, 16'h0000, "R8");
    wr_reg(8'h38, 16'h0106);
    rd_chk(8'h3A, "R8", v1);
    rd_chk(8'h3A, "R8", v2);
    checks++;
    if (v1 !== v2) begin
      errors++;
      $display("FAIL R8 repeated read actual=%h expected=%h", v2, v1);
    end
    rd_exp(8'h38, 16'h0106, "R8");
    idle(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule